// File: doc/BRIEF.md
# Host I/O Cycle Decoder

This block sits at the host bridge and looks at every processor I/O transaction. It compares the I/O address with two internal register locations. One is the configuration address port. The other is the four-byte configuration data window. A match is claimed, and the block raises a read or write strobe for the register engine that sits behind it. Every other access is marked for forwarding to the downstream link. The address goes out exactly as it arrived.

A multi-byte access that starts near the top of the 64 KB I/O space runs past 0xFFFF. For such an access the decoder sets a seventeenth address bit. This makes three extra byte locations reachable, and they can only be reached this way. The decoder also derives the four byte-lane enables from the access size and the low address bits.

All results are registered. Each request appears on the outputs one clock after it is presented. The enable bit of the configuration address register is held by the register engine and is fed back to this block as an input.

Top module: `io_cycle_decoder`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `out_valid`, `out_claim`, `out_fwd` and all four register strobes are 0.
- R2: A request presented with `req_valid`=1 at a rising edge appears on the outputs with `out_valid`=1 right after that edge, which is one cycle of latency.
- R3: A request at address 0x0CF8 with size code 2 or 3 (four bytes) is claimed (`out_claim`=1, `out_fwd`=0). It pulses `cfg_addr_wr` if `req_write`=1 and `cfg_addr_rd` otherwise. The same address with size code 0 or 1 is forwarded.
- R4: A request at any address from 0x0CFC to 0x0CFF, of any size, is claimed and pulses `cfg_data_wr` or `cfg_data_rd` when `cfg_en`=1. When `cfg_en`=0 it is forwarded and no strobe fires.
- R5: Every request that R3 and R4 do not claim is forwarded (`out_fwd`=1, `out_claim`=0, no strobe). Each valid output has exactly one of `out_claim` and `out_fwd` set.
- R6: `out_addr[15:0]` equals the request address, both for claimed and for forwarded requests.
- R7: `out_addr[16]` is 1 only in two cases: a four-byte access (size code 2 or 3) starting at 0xFFFD, 0xFFFE or 0xFFFF, and a two-byte access (size code 1) starting at 0xFFFF. For every other access it is 0.
- R8: Size code 0 means 1 byte, 1 means 2 bytes, and 2 or 3 mean 4 bytes. `out_be[i]` is 1 exactly when lane i lies in the range off to off+n-1, where off is `req_addr[1:0]` and n is the byte count.
- R9: A cycle with `req_valid`=0 gives `out_valid`=0 and no strobe after the next edge, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | I/O request present this cycle |
| req_addr | input | 16 | I/O start address |
| req_size | input | 2 | Size code: 0=1 byte, 1=2 bytes, 2/3=4 bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| cfg_en | input | 1 | Enable bit of the configuration address register |
| out_valid | output | 1 | Registered result valid |
| out_claim | output | 1 | Access claimed internally |
| out_fwd | output | 1 | Access forwarded downstream |
| out_addr | output | 17 | Forwarded address, bit 16 set on wrap-around |
| out_be | output | 4 | Byte-lane enables |
| cfg_addr_rd | output | 1 | Read strobe, configuration address register |
| cfg_addr_wr | output | 1 | Write strobe, configuration address register |
| cfg_data_rd | output | 1 | Read strobe, configuration data register |
| cfg_data_wr | output | 1 | Write strobe, configuration data register |

## Verification
Two decisions can fall on the same request: generating the wrap bit and choosing between claim and forward. The byte-lane enables are computed for that request as well. The bench provokes this with directed accesses of every size at 0xFFFC to 0xFFFF and at 0x0CF8 to 0x0CFF, repeated with `cfg_en` both high and low. It also sends random requests weighted toward those two windows. Each result is judged field by field against a bench model. The model must show a wrapped access as forwarded, with the address bit set and the lanes computed from the low address bits. It must show a claimed data-window access that has neither the wrap bit nor a forward flag.

// File: rtl/iodec_pkg.sv
package iodec_pkg;

  typedef enum logic [1:0] {
    SZ_ONE  = 2'd0,
    SZ_TWO  = 2'd1,
    SZ_FOUR = 2'd2,
    SZ_FOUR_ALT = 2'd3
  } io_size_e;

  typedef struct packed {
    logic claim;
    logic fwd;
    logic ca_rd;
    logic ca_wr;
    logic cd_rd;
    logic cd_wr;
  } io_route_t;

  function automatic int unsigned size_bytes(input logic [1:0] code);
    case (io_size_e'(code))
      SZ_ONE:  return 1;
      SZ_TWO:  return 2;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/io_lane_gen.sv
module io_lane_gen #(
  parameter int ADDR_W = 16,
  parameter int LANES  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic [LANES-1:0]  be,
  output logic              wrap
);
  import iodec_pkg::*;

  localparam int OFF_W = $clog2(LANES);

  logic [ADDR_W:0] last_byte;
  int unsigned     nbytes;
  int unsigned     off;

  always_comb begin
    nbytes    = size_bytes(size);
    off       = int'(addr[OFF_W-1:0]);
    last_byte = {1'b0, addr} + (ADDR_W+1)'(nbytes - 1);
    wrap      = last_byte[ADDR_W];
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign be[i] = (i >= off) && (i < off + nbytes);
  end

endmodule

// File: rtl/io_port_match.sv
module io_port_match #(
  parameter int              ADDR_W  = 16,
  parameter int              LANES   = 4,
  parameter logic [ADDR_W-1:0] CA_PORT = 16'h0CF8,
  parameter logic [ADDR_W-1:0] CD_PORT = 16'h0CFC
) (
  input  logic                 valid,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [1:0]           size,
  input  logic                 write,
  input  logic                 cfg_en,
  output iodec_pkg::io_route_t route
);
  import iodec_pkg::*;

  localparam int OFF_W = $clog2(LANES);

  logic ca_hit;
  logic cd_hit;

  always_comb begin
    ca_hit = (addr == CA_PORT) && (size_bytes(size) == LANES);
    cd_hit = (addr[ADDR_W-1:OFF_W] == CD_PORT[ADDR_W-1:OFF_W]) && cfg_en;

    route       = '0;
    route.claim = valid && (ca_hit || cd_hit);
    route.fwd   = valid && !(ca_hit || cd_hit);
    route.ca_rd = valid && ca_hit && !write;
    route.ca_wr = valid && ca_hit && write;
    route.cd_rd = valid && cd_hit && !write;
    route.cd_wr = valid && cd_hit && write;
  end

endmodule

// File: rtl/io_cycle_decoder.sv
module io_cycle_decoder #(
  parameter int                ADDR_W  = 16,
  parameter int                LANES   = 4,
  parameter logic [ADDR_W-1:0] CA_PORT = 16'h0CF8,
  parameter logic [ADDR_W-1:0] CD_PORT = 16'h0CFC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic              cfg_en,
  output logic              out_valid,
  output logic              out_claim,
  output logic              out_fwd,
  output logic [ADDR_W:0]   out_addr,
  output logic [LANES-1:0]  out_be,
  output logic              cfg_addr_rd,
  output logic              cfg_addr_wr,
  output logic              cfg_data_rd,
  output logic              cfg_data_wr
);
  import iodec_pkg::*;

  logic [LANES-1:0] be_n;
  logic             wrap_n;
  io_route_t        route_n;
  io_route_t        route_q;

  io_lane_gen #(.ADDR_W(ADDR_W), .LANES(LANES)) u_lane (
    .addr (req_addr),
    .size (req_size),
    .be   (be_n),
    .wrap (wrap_n)
  );

  io_port_match #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .CA_PORT(CA_PORT),
    .CD_PORT(CD_PORT)
  ) u_match (
    .valid (req_valid),
    .addr  (req_addr),
    .size  (req_size),
    .write (req_write),
    .cfg_en(cfg_en),
    .route (route_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      route_q   <= '0;
      out_addr  <= '0;
      out_be    <= '0;
    end else begin
      out_valid <= req_valid;
      route_q   <= route_n;
      out_addr  <= {wrap_n, req_addr};
      out_be    <= be_n;
    end
  end

  assign out_claim   = route_q.claim;
  assign out_fwd     = route_q.fwd;
  assign cfg_addr_rd = route_q.ca_rd;
  assign cfg_addr_wr = route_q.ca_wr;
  assign cfg_data_rd = route_q.cd_rd;
  assign cfg_data_wr = route_q.cd_wr;

endmodule

// File: rtl/io_cycle_decoder_chk.sv
module io_cycle_decoder_chk #(
  parameter int ADDR_W = 16,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              cfg_en,
  input logic              out_valid,
  input logic              out_claim,
  input logic              out_fwd,
  input logic [ADDR_W:0]   out_addr,
  input logic [LANES-1:0]  out_be,
  input logic              cfg_addr_rd,
  input logic              cfg_addr_wr,
  input logic              cfg_data_rd,
  input logic              cfg_data_wr
);

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid && !(cfg_addr_rd || cfg_addr_wr || cfg_data_rd || cfg_data_wr));

  // R5
  route_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $countones({out_claim, out_fwd}) == 1);

  // R3
  strobe_claim_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cfg_addr_rd, cfg_addr_wr, cfg_data_rd, cfg_data_wr}) &&
    ((cfg_addr_rd || cfg_addr_wr || cfg_data_rd || cfg_data_wr) -> out_claim));

  // R4
  data_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !cfg_en) |=> !(cfg_data_rd || cfg_data_wr));

  // R6
  addr_pass_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_addr[ADDR_W-1:0] == $past(req_addr));

  // R7
  wrap_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_addr[ADDR_W]) |-> out_fwd);

  // R8
  lane_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_be != '0);

endmodule

bind io_cycle_decoder io_cycle_decoder_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_addr   (req_addr),
  .cfg_en     (cfg_en),
  .out_valid  (out_valid),
  .out_claim  (out_claim),
  .out_fwd    (out_fwd),
  .out_addr   (out_addr),
  .out_be     (out_be),
  .cfg_addr_rd(cfg_addr_rd),
  .cfg_addr_wr(cfg_addr_wr),
  .cfg_data_rd(cfg_data_rd),
  .cfg_data_wr(cfg_data_wr)
);

// File: tb/io_cycle_decoder_bench.sv
module io_cycle_decoder_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic        cfg_en = 1'b0;
  logic        out_valid, out_claim, out_fwd;
  logic [16:0] out_addr;
  logic [3:0]  out_be;
  logic        cfg_addr_rd, cfg_addr_wr, cfg_data_rd, cfg_data_wr;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  io_cycle_decoder u_io_cycle_decoder (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .cfg_en(cfg_en),
    .out_valid(out_valid), .out_claim(out_claim), .out_fwd(out_fwd),
    .out_addr(out_addr), .out_be(out_be),
    .cfg_addr_rd(cfg_addr_rd), .cfg_addr_wr(cfg_addr_wr),
    .cfg_data_rd(cfg_data_rd), .cfg_data_wr(cfg_data_wr)
  );

  function automatic int nb(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic exp_wrap(input logic [15:0] a, input logic [1:0] s);
    return (int'(a) + nb(s) - 1) > 65535;
  endfunction

  function automatic logic [3:0] exp_be(input logic [15:0] a, input logic [1:0] s);
    logic [3:0] m;
    for (int i = 0; i < 4; i++) m[i] = (i >= int'(a[1:0])) && (i < int'(a[1:0]) + nb(s));
    return m;
  endfunction

  // returns {claim, fwd, ca_rd, ca_wr, cd_rd, cd_wr}
  function automatic logic [5:0] exp_route(input logic [15:0] a, input logic [1:0] s,
                                           input logic w, input logic en);
    logic ca, cd;
    ca = (a == 16'h0CF8) && (nb(s) == 4);
    cd = (a >= 16'h0CFC) && (a <= 16'h0CFF) && en;
    return {ca || cd, !(ca || cd), ca && !w, ca && w, cd && !w, cd && w};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (addr %h size %0d)", tag, act, exp, req_addr, req_size);
    end
  endtask

  task automatic do_req(input logic [15:0] a, input logic [1:0] s, input logic w, input logic en);
    logic [5:0] r;
    string tag;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = s; req_write = w; cfg_en = en;
    @(posedge clk); #1;
    r = exp_route(a, s, w, en);
    if (a == 16'h0CF8) tag = "R3 route";
    else if (a >= 16'h0CFC && a <= 16'h0CFF) tag = "R4 route";
    else tag = "R5 route";
    check("R2 valid", 32'(out_valid), 32'd1);
    check(tag, 32'({out_claim, out_fwd, cfg_addr_rd, cfg_addr_wr, cfg_data_rd, cfg_data_wr}), 32'(r));
    check("R6 addr", 32'(out_addr[15:0]), 32'(a));
    check("R7 wrap", 32'(out_addr[16]), 32'(exp_wrap(a, s)));
    check("R8 be", 32'(out_be), 32'(exp_be(a, s)));
  endtask

  task automatic do_idle(input logic [15:0] a);
    @(negedge clk);
    req_valid = 1'b0; req_addr = a; req_size = 2'd2; req_write = 1'b1; cfg_en = 1'b1;
    @(posedge clk); #1;
    check("R9 idle", 32'({out_valid, cfg_addr_rd, cfg_addr_wr, cfg_data_rd, cfg_data_wr}), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 reset", 32'({out_valid, out_claim, out_fwd, cfg_addr_rd, cfg_addr_wr, cfg_data_rd, cfg_data_wr}), 32'd0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check("R1 after reset", 32'({out_valid, out_claim, out_fwd, cfg_addr_rd, cfg_addr_wr, cfg_data_rd, cfg_data_wr}), 32'd0);

    // directed corners: top of space and config windows, all sizes, both enables
    for (int e = 0; e < 2; e++)
      for (int s = 0; s < 4; s++)
        for (int k = 0; k < 4; k++) begin
          do_req(16'hFFFC + 16'(k), 2'(s), 1'(k & 1), 1'(e));
          do_req(16'h0CF8 + 16'(k), 2'(s), 1'(e), 1'(e));
          do_req(16'h0CFC + 16'(k), 2'(s), 1'(k >> 1), 1'(e));
        end
    do_idle(16'h0CF8);
    do_idle(16'h0CFC);

    // constrained random, weighted toward the interesting windows
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] a;
      int pick;
      pick = int'($urandom_range(0, 9));
      if (pick < 3)      a = 16'h0CF4 + 16'($urandom_range(0, 15));
      else if (pick < 5) a = 16'hFFF8 + 16'($urandom_range(0, 7));
      else               a = 16'($urandom);
      if (pick == 9) do_idle(a);
      else do_req(a, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule